// File: doc/BRIEF.md
# Keypad Four-Function Calculator Sequencer

This block is the control and arithmetic core of a small integer calculator. It accepts one 4-bit key code per valid strobe. The key codes come from an external keypad scanner that already debounces the keys. Digit keys build the operand being entered in decimal. The first operator key stores the operator and moves entry to a second operand, which starts at zero. Any later operator key applies the stored operator. The result becomes the new first operand, and the key just pressed becomes the pending operator. The block therefore chains operations, as a pocket calculator does when the operators are pressed one after another.

All values are unsigned integers. They are limited to `DIGITS` decimal digits, held in `W` bits. The output is the binary value of the operand being entered. An external stage converts it to decimal and drives the display. A result-ready level marks that the value shown is a computed result. An error level marks that the computation failed and that zero was loaded in its place.

Top module: `calc_seq`

## Requirements
- R1: After reset, `disp_value` is 0, `result_ready` and `calc_err` are 0, entry is on the first operand, and the pending operator is add.
- R2: A digit key (codes 0 to 9) sets the active operand to operand*10 + digit.
- R3: A digit key is ignored if the new value would exceed 10**DIGITS-1 (9999 by default). The display and both flags are left unchanged.
- R4: With the first operand active, an operator key (codes 10 to 13) stores that operator and moves entry to the second operand. The display then shows 0.
- R5: With the second operand active, an operator key applies the stored operator to the two operands. The result is written into the first operand and the second operand is cleared. Entry returns to the first operand, the new key becomes the pending operator, and `result_ready` goes to 1.
- R6: The operator codes are 10 for add, 11 for subtract, 12 for multiply and 13 for divide. Division truncates toward zero.
- R7: Three cases are errors: a result above 10**DIGITS-1, a subtraction with a negative result, and division by zero. Each error sets `calc_err` and `result_ready` and loads 0 as the result.
- R8: Key codes 14 and 15 are ignored in every state. The display and both flags are left unchanged.
- R9: `disp_value` always equals the operand being entered. It changes on the clock edge that accepts the key, and it never changes while no key is presented.
- R10: `result_ready` and `calc_err` stay set until the next accepted key, which clears them unless that key itself computes a result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_valid | input | 1 | Strobe marking a valid key code for one cycle |
| key_code | input | 4 | Key code: 0-9 digit, 10-13 operator, 14-15 unused |
| disp_value | output | W | Binary value of the operand being entered |
| result_ready | output | 1 | The displayed value is a computed result |
| calc_err | output | 1 | The last computation failed and produced 0 |

## Verification
The bench builds the block with its defaults, W = 14 and DIGITS = 4. This puts the 9999 ceiling within reach through short key sequences. The sequences include 99*101 landing exactly on the limit, a fifth digit refused at the limit, and 9999+1 stepping past it. A single chained sequence also covers a negative subtraction, division by zero, truncating division and multiplication by zero. Along the way it checks that unused codes and idle cycles leave the display and the flags untouched.

// File: rtl/calc_seq.sv
module calc_seq #(
  parameter int W      = 14,
  parameter int DIGITS = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         key_valid,
  input  logic [3:0]   key_code,
  output logic [W-1:0] disp_value,
  output logic         result_ready,
  output logic         calc_err
);
  localparam int          MAXV   = 10**DIGITS - 1;
  localparam logic [3:0]  OP_ADD = 4'd10;
  localparam logic [3:0]  OP_SUB = 4'd11;
  localparam logic [3:0]  OP_MUL = 4'd12;
  localparam logic [3:0]  OP_DIV = 4'd13;

  logic [W-1:0] opa, opb;
  logic [3:0]   pend_op;
  logic         second;

  wire [W-1:0] cur    = second ? opb : opa;
  wire         is_dig = key_code < 4'd10;
  wire         is_op  = (key_code >= OP_ADD) && (key_code <= OP_DIV);
  wire [W+3:0] app    = (W+4)'(cur) * (W+4)'(10) + (W+4)'(key_code);
  wire         dig_ok = key_valid && is_dig && (app <= (W+4)'(MAXV));
  wire         op_hit = key_valid && is_op;

  logic [2*W-1:0] res;
  logic           bad;

  always_comb begin
    res = '0;
    bad = 1'b0;
    case (pend_op)
      OP_ADD: res = (2*W)'(opa) + (2*W)'(opb);
      OP_SUB: begin
        bad = opb > opa;
        res = (2*W)'(opa - opb);
      end
      OP_MUL: res = (2*W)'(opa) * (2*W)'(opb);
      default: begin
        bad = opb == '0;
        res = bad ? '0 : (2*W)'(opa / opb);
      end
    endcase
    if (res > (2*W)'(MAXV)) bad = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opa          <= '0;
      opb          <= '0;
      pend_op      <= OP_ADD;
      second       <= 1'b0;
      result_ready <= 1'b0;
      calc_err     <= 1'b0;
    end else if (dig_ok) begin
      if (second) opb <= app[W-1:0];
      else        opa <= app[W-1:0];
      result_ready <= 1'b0;
      calc_err     <= 1'b0;
    end else if (op_hit) begin
      pend_op <= key_code;
      opb     <= '0;
      if (!second) begin
        second       <= 1'b1;
        result_ready <= 1'b0;
        calc_err     <= 1'b0;
      end else begin
        second       <= 1'b0;
        opa          <= bad ? '0 : res[W-1:0];
        result_ready <= 1'b1;
        calc_err     <= bad;
      end
    end
  end

  assign disp_value = cur;
endmodule

module calc_seq_chk #(
  parameter int W      = 14,
  parameter int DIGITS = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         key_valid,
  input logic [3:0]   key_code,
  input logic [W-1:0] disp_value,
  input logic         result_ready,
  input logic         calc_err
);
  localparam int MAXV = 10**DIGITS - 1;

  AST_DISP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    disp_value <= W'(MAXV)) else $error("display above limit"); // R3
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !key_valid |=> $stable(disp_value) && $stable(result_ready) && $stable(calc_err)); // R9
  AST_UNUSED_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (key_valid && key_code >= 4'd14) |=> $stable(disp_value) && $stable(result_ready) && $stable(calc_err)); // R8
  AST_READY_FROM_OP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(result_ready) |-> $past(key_valid && key_code >= 4'd10 && key_code <= 4'd13)); // R5
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    calc_err |-> (disp_value == '0) && result_ready); // R7
  AST_OP_CLEARS_DISP: assert property (@(posedge clk) disable iff (!rst_n)
    (key_valid && key_code >= 4'd10 && key_code <= 4'd13 && !result_ready) |=> disp_value == '0 || result_ready); // R4
endmodule

bind calc_seq calc_seq_chk #(.W(W), .DIGITS(DIGITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_code(key_code),
  .disp_value(disp_value), .result_ready(result_ready), .calc_err(calc_err)
);

// File: tb/tb_calc_seq.sv
module tb_calc_seq;
  localparam int W = 14;
  localparam int DIGITS = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         key_valid = 1'b0;
  logic [3:0]   key_code = '0;
  logic [W-1:0] disp_value;
  logic         result_ready, calc_err;
  int n_chk = 0, n_bad = 0;

  calc_seq #(.W(W), .DIGITS(DIGITS)) dut (.*);

  always #2 clk = ~clk;

  typedef struct packed {
    logic [3:0]   code;
    logic [W-1:0] disp;
    logic         rdy;
    logic         err;
    logic [23:0]  tag;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t VEC [NV] = '{
    '{4'd1,  14'd1,    1'b0, 1'b0, "R2"},
    '{4'd2,  14'd12,   1'b0, 1'b0, "R2"},
    '{4'd13, 14'd0,    1'b0, 1'b0, "R4"},
    '{4'd3,  14'd3,    1'b0, 1'b0, "R2"},
    '{4'd10, 14'd4,    1'b1, 1'b0, "R6"},   // 12/3
    '{4'd5,  14'd45,   1'b0, 1'b0, "R10"},
    '{4'd11, 14'd0,    1'b0, 1'b0, "R4"},
    '{4'd4,  14'd4,    1'b0, 1'b0, "R2"},
    '{4'd6,  14'd46,   1'b0, 1'b0, "R2"},
    '{4'd12, 14'd0,    1'b1, 1'b1, "R7"},   // 45-46
    '{4'd9,  14'd9,    1'b0, 1'b0, "R10"},
    '{4'd9,  14'd99,   1'b0, 1'b0, "R2"},
    '{4'd12, 14'd0,    1'b0, 1'b0, "R4"},
    '{4'd1,  14'd1,    1'b0, 1'b0, "R2"},
    '{4'd0,  14'd10,   1'b0, 1'b0, "R2"},
    '{4'd1,  14'd101,  1'b0, 1'b0, "R2"},
    '{4'd10, 14'd9999, 1'b1, 1'b0, "R5"},   // 99*101
    '{4'd14, 14'd9999, 1'b1, 1'b0, "R8"},
    '{4'd7,  14'd9999, 1'b1, 1'b0, "R3"},
    '{4'd15, 14'd9999, 1'b1, 1'b0, "R8"},
    '{4'd11, 14'd0,    1'b0, 1'b0, "R4"},
    '{4'd10, 14'd9999, 1'b1, 1'b0, "R6"},   // 9999-0
    '{4'd10, 14'd0,    1'b0, 1'b0, "R4"},
    '{4'd1,  14'd1,    1'b0, 1'b0, "R2"},
    '{4'd10, 14'd0,    1'b1, 1'b1, "R7"},   // 9999+1
    '{4'd13, 14'd0,    1'b0, 1'b0, "R10"},
    '{4'd13, 14'd0,    1'b1, 1'b1, "R7"},   // 0/0
    '{4'd7,  14'd7,    1'b0, 1'b0, "R2"},
    '{4'd12, 14'd0,    1'b0, 1'b0, "R4"},
    '{4'd10, 14'd0,    1'b1, 1'b0, "R6"},   // 7*0
    '{4'd8,  14'd8,    1'b0, 1'b0, "R10"}
  };

  task automatic check(input logic [23:0] tag, input logic [W-1:0] ed,
                       input logic er, input logic ee);
    n_chk++;
    if (disp_value !== ed || result_ready !== er || calc_err !== ee) begin
      n_bad++;
      $display("FAIL %s: disp/rdy/err = %0d/%0b/%0b expected %0d/%0b/%0b",
               tag, disp_value, result_ready, calc_err, ed, er, ee);
    end
  endtask

  task automatic press(input logic [3:0] c);
    @(negedge clk);
    key_valid = 1'b1;
    key_code  = c;
    @(negedge clk);
    key_valid = 1'b0;
    key_code  = 4'd0;
  endtask

  initial begin
    #200000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", '0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", '0, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      press(VEC[i].code);
      check(VEC[i].tag, VEC[i].disp, VEC[i].rdy, VEC[i].err);
    end

    // R9: idle cycles keep the display
    repeat (5) @(negedge clk);
    check("R9", 14'd8, 1'b0, 1'b0);

    // R9: display follows the accepting edge, not earlier
    @(negedge clk);
    key_valid = 1'b1;
    key_code  = 4'd3;
    #1;
    check("R9", 14'd8, 1'b0, 1'b0);
    @(negedge clk);
    key_valid = 1'b0;
    check("R9", 14'd83, 1'b0, 1'b0);

    // R1: reset in the middle of second-operand entry
    press(4'd10);
    press(4'd5);
    check("R2", 14'd5, 1'b0, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", '0, 1'b0, 1'b0);
    rst_n = 1'b1;
    // R1: pending operator after reset is add; first then second operand
    press(4'd6);
    press(4'd13);
    press(4'd4);
    press(4'd10);
    check("R6", 14'd1, 1'b1, 1'b0);   // 6/4 truncates
    press(4'd2);
    press(4'd10);
    press(4'd3);
    press(4'd11);
    check("R5", 14'd15, 1'b1, 1'b0);  // 12+3

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule